// File: doc/BRIEF.md
# Processor Port Memory Bank Decoder

This block holds a two-register processor port that sits at CPU addresses 0 and 1, and the decoder that uses it to pick the device behind every CPU bus access in a 64K memory map. Address 0 is the direction register, where a 1 makes a pin an output. Address 1 is the data register. The low three effective port bits are the bank controls: `lo_en` (bit 0), `hi_en` (bit 1) and `io_en` (bit 2). They decide whether a read in the A000-BFFF, D000-DFFF and E000-FFFF windows sees a ROM, the character ROM, the I/O space or RAM.

A write into a window where a ROM is visible lands in the RAM beneath it. The I/O space takes both reads and writes. Each port bit that is set as an input carries a pull-up into the bank logic. After reset all eight pins are inputs, so the BASIC ROM, the system ROM and I/O are all visible. When the CPU reads a pin that is set as an input, it sees the external level on that pin and not the stored data bit.

The decoder raises one chip select per cycle. The selects are combinational from the address, the write strobe and the registered port state, so a store to the port changes the map from the next bus cycle onward.

Top module: `cpu_bank_port`

## Requirements
- R1: After reset both port registers are 0. A read at A000 selects the BASIC ROM, a read at E000 selects the system ROM and a read at D000 selects I/O.
- R2: A read at address 0 asserts `port_hit` and returns the direction register on `port_rdata`. A write at address 0 loads that register.
- R3: A read at address 1 asserts `port_hit` and returns, bit by bit, the data register where the direction bit is 1 and `pin_in` where it is 0. A write at address 1 loads the data register.
- R4: A read at A000-BFFF selects the BASIC ROM when `lo_en` and `hi_en` are both 1. Otherwise it selects RAM.
- R5: A read at E000-FFFF selects the system ROM when `hi_en` is 1. Otherwise it selects RAM.
- R6: A read at D000-DFFF selects RAM when `lo_en` and `hi_en` are both 0. Otherwise it selects I/O when `io_en` is 1 and the character ROM when `io_en` is 0.
- R7: A write at A000-BFFF or E000-FFFF always selects RAM. A write at D000-DFFF selects I/O under the same condition as R6, and RAM in every other case.
- R8: An effective bank bit whose direction bit is 0 reads as 1, whatever the data register holds.
- R9: A port write changes the decode starting with the very next cycle. Without a port write the registers hold their values.
- R10: Exactly one of the five chip selects is active in every cycle.
- R11: An access at address 0 or 1 also selects RAM, so port writes pass through to the RAM underneath.
- R12: Any address outside the three windows selects RAM for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address of this cycle |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_wdata | input | 8 | CPU write data |
| pin_in | input | 8 | External levels on the port pins |
| sel_ram | output | 1 | RAM chip select |
| sel_basic | output | 1 | BASIC ROM chip select |
| sel_kernal | output | 1 | System ROM chip select |
| sel_char | output | 1 | Character ROM chip select |
| sel_io | output | 1 | I/O space chip select |
| port_hit | output | 1 | Read of address 0 or 1; CPU data comes from `port_rdata` |
| port_rdata | output | 8 | Port readback value, 0 when `port_hit` is low |

## Verification
A corrupted direction or data register shows up in the first read after the store that set it. Two things reveal it: the readback of address 0 or 1, and the select chosen in the three windows. The bench therefore reads the windows on the cycle right after each port write. A fault in the pull-up path appears only while pins are inputs, so the decode is checked both before and after the direction register is loaded. A read-versus-write decode fault shows up as a select in the same cycle, so every window is also written while a ROM is visible.

// File: rtl/bank_port_pkg.sv
package bank_port_pkg;
    parameter int PORT_W = 8;
    parameter int ADDR_W = 16;
    parameter int BANK_W = 3;

    localparam int LO_BIT = 0;
    localparam int HI_BIT = 1;
    localparam int IO_BIT = 2;

    localparam logic [3:0] NIB_A = 4'hA;
    localparam logic [3:0] NIB_B = 4'hB;
    localparam logic [3:0] NIB_D = 4'hD;
    localparam logic [3:0] NIB_E = 4'hE;
    localparam logic [3:0] NIB_F = 4'hF;

    typedef struct packed {
        logic ram;
        logic basic;
        logic kernal;
        logic chr;
        logic io;
    } sel_t;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] data;
    } port_regs_t;
endpackage

// File: rtl/bank_port_regs.sv
module bank_port_regs
    import bank_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [PORT_W-1:0] wdata,
    output port_regs_t        regs_q
);
    port_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (we && addr == ADDR_W'(0)) regs_d.dir  = wdata;
        if (we && addr == ADDR_W'(1)) regs_d.data = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R2: a direction store is visible next cycle
    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(0)) |=> regs_q.dir == $past(wdata));
    // R3: a data store is visible next cycle
    p_data_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(1)) |=> regs_q.data == $past(wdata));
    // R9: registers hold without a write
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));
endmodule

// File: rtl/bank_map_decode.sv
module bank_map_decode
    import bank_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    output sel_t              sel
);
    localparam int TOP = ADDR_W - 1;

    logic [3:0] nib;
    logic       win_a, win_d, win_e;
    logic       any_rom;

    always_comb begin
        nib     = addr[TOP -: 4];
        win_a   = (nib == NIB_A) || (nib == NIB_B);
        win_d   = (nib == NIB_D);
        win_e   = (nib == NIB_E) || (nib == NIB_F);
        any_rom = bank[LO_BIT] | bank[HI_BIT];
        sel     = '0;
        if (win_a && !we && bank[LO_BIT] && bank[HI_BIT]) begin
            sel.basic = 1'b1;
        end else if (win_e && !we && bank[HI_BIT]) begin
            sel.kernal = 1'b1;
        end else if (win_d && any_rom && bank[IO_BIT]) begin
            sel.io = 1'b1;
        end else if (win_d && any_rom && !we) begin
            sel.chr = 1'b1;
        end else begin
            sel.ram = 1'b1;
        end
    end

    // R10: one select per cycle
    p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);
    // R7: writes under ROM windows land in RAM
    p_write_under_rom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (win_a || win_e)) |-> sel.ram);
    // R12: outside the windows only RAM answers
    p_plain_ram_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_a || win_d || win_e) |-> sel.ram);
endmodule

// File: rtl/cpu_bank_port.sv
module cpu_bank_port
    import bank_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] PULLUP = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [PORT_W-1:0] cpu_wdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic              sel_ram,
    output logic              sel_basic,
    output logic              sel_kernal,
    output logic              sel_char,
    output logic              sel_io,
    output logic              port_hit,
    output logic [PORT_W-1:0] port_rdata
);
    port_regs_t        regs_q;
    sel_t              sel;
    logic [PORT_W-1:0] eff_bits;
    logic [PORT_W-1:0] pin_view;

    bank_port_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (cpu_addr),
        .we     (cpu_we),
        .wdata  (cpu_wdata),
        .regs_q (regs_q)
    );

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        assign eff_bits[b] = regs_q.dir[b] ? regs_q.data[b] : PULLUP[b];
        assign pin_view[b] = regs_q.dir[b] ? regs_q.data[b] : pin_in[b];
    end

    bank_map_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cpu_addr),
        .we    (cpu_we),
        .bank  (eff_bits[BANK_W-1:0]),
        .sel   (sel)
    );

    always_comb begin
        sel_ram    = sel.ram;
        sel_basic  = sel.basic;
        sel_kernal = sel.kernal;
        sel_char   = sel.chr;
        sel_io     = sel.io;
        port_hit   = !cpu_we && (cpu_addr == ADDR_W'(0) || cpu_addr == ADDR_W'(1));
        port_rdata = '0;
        if (port_hit) port_rdata = (cpu_addr[0]) ? pin_view : regs_q.dir;
    end

    // R11: port addresses still reach RAM
    p_port_to_ram_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == ADDR_W'(0) || cpu_addr == ADDR_W'(1)) |-> sel_ram);
    // R8: input pins keep bank bits high
    p_pullup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.dir[BANK_W-1:0] == '0) |-> eff_bits[BANK_W-1:0] == '1);
endmodule

// File: tb/cpu_bank_port_bench.sv
module cpu_bank_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  pin_in = 8'h5A;
    logic        sel_ram, sel_basic, sel_kernal, sel_char, sel_io, port_hit;
    logic [7:0]  port_rdata;

    typedef struct {
        logic [4:0] sel;
        logic       hit;
        logic [7:0] rd;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    logic [7:0] m_dir = '0;
    logic [7:0] m_data = '0;
    bit done = 0;

    always #10 clk = ~clk;

    cpu_bank_port u_cpu_bank_port (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .pin_in(pin_in), .sel_ram(sel_ram),
        .sel_basic(sel_basic), .sel_kernal(sel_kernal), .sel_char(sel_char),
        .sel_io(sel_io), .port_hit(port_hit), .port_rdata(port_rdata)
    );

    // sel order: {ram, basic, kernal, char, io}
    function automatic item_t expect_of(logic [15:0] a, logic w, string req);
        item_t it;
        logic [7:0] eff;
        logic lo, hi, ioe;
        eff = (m_data & m_dir) | ~m_dir;
        lo = eff[0]; hi = eff[1]; ioe = eff[2];
        it.req = req;
        it.sel = 5'b10000;
        if (a[15:13] == 3'b101 && !w && lo && hi)            it.sel = 5'b01000;
        else if (a[15:13] == 3'b111 && !w && hi)             it.sel = 5'b00100;
        else if (a[15:12] == 4'hD && (lo || hi) && ioe)      it.sel = 5'b00001;
        else if (a[15:12] == 4'hD && (lo || hi) && !w)       it.sel = 5'b00010;
        it.hit = !w && (a == 16'h0000 || a == 16'h0001);
        it.rd  = 8'h00;
        if (it.hit) it.rd = (a == 16'h0000) ? m_dir : ((m_data & m_dir) | (pin_in & ~m_dir));
        return it;
    endfunction

    task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d, input string req);
        cpu_addr = a; cpu_we = w; cpu_wdata = d;
        q.push_back(expect_of(a, w, req));
        if (w && a == 16'h0000) m_dir = d;
        if (w && a == 16'h0001) m_data = d;
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t e;
                logic [4:0] got;
                e = q.pop_front();
                got = {sel_ram, sel_basic, sel_kernal, sel_char, sel_io};
                checks++;
                if (got != e.sel || port_hit != e.hit || port_rdata != e.rd) begin
                    errors++;
                    $display("FAIL %s: sel=%b hit=%b rd=%h expected sel=%b hit=%b rd=%h",
                             e.req, got, port_hit, port_rdata, e.sel, e.hit, e.rd);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset map, R2/R3 readback
        access(16'hA000, 0, 0, "R1 basic after reset");
        access(16'hE123, 0, 0, "R1 kernal after reset");
        access(16'hD400, 0, 0, "R1 io after reset");
        access(16'h0000, 0, 0, "R2 dir reads 0");
        access(16'h0001, 0, 0, "R3 inputs show pins");
        // R8 data cleared but pins are inputs
        access(16'h0001, 1, 8'h00, "R11 write data to RAM");
        access(16'hBFFF, 0, 0, "R8 pullup keeps basic");
        access(16'hD000, 0, 0, "R8 pullup keeps io");
        // R9 dir write takes effect next cycle
        access(16'h0000, 1, 8'h07, "R11 write dir to RAM");
        access(16'hA000, 0, 0, "R9 R4 basic gone");
        access(16'hF000, 0, 0, "R5 kernal gone");
        access(16'hD800, 0, 0, "R6 ram when lo hi low");
        access(16'hD800, 1, 8'h11, "R7 D write ram");
        access(16'h0000, 0, 0, "R2 dir readback 07");
        // lo=1 hi=1 io=0
        access(16'h0001, 1, 8'h03, "R11 data write");
        access(16'hA000, 0, 0, "R9 R4 basic back");
        access(16'hE000, 0, 0, "R5 kernal visible");
        access(16'hD000, 0, 0, "R6 char rom");
        access(16'hD000, 1, 8'h22, "R7 write under char");
        access(16'hA000, 1, 8'h33, "R7 write under basic");
        access(16'hFFFF, 1, 8'h44, "R7 write under kernal");
        // lo=0 hi=1 io=1
        access(16'h0001, 1, 8'h06, "R11 data write");
        access(16'hA000, 0, 0, "R4 ram with lo low");
        access(16'hE000, 0, 0, "R5 kernal with hi");
        access(16'hDC00, 0, 0, "R6 io");
        access(16'hDC00, 1, 8'h55, "R7 io write");
        // lo=1 hi=0 io=0 then io=1
        access(16'h0001, 1, 8'h01, "R11 data write");
        access(16'hA000, 0, 0, "R4 ram with hi low");
        access(16'hE000, 0, 0, "R5 ram with hi low");
        access(16'hD000, 0, 0, "R6 char with lo only");
        access(16'h0001, 1, 8'h05, "R11 data write");
        access(16'hD000, 0, 0, "R6 io with lo only");
        access(16'h0001, 0, 0, "R3 mixed readback");
        pin_in = 8'hA5;
        access(16'h0001, 0, 0, "R3 mixed readback new pins");
        // R12 other addresses
        access(16'h2000, 0, 0, "R12 low ram read");
        access(16'hC000, 1, 8'h66, "R12 C page write");
        access(16'h9FFF, 0, 0, "R12 below A window");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule